// File: doc/BRIEF.md
# Host/Function Doorbell Mailbox Bank

This block holds one 32-bit mailbox word for each virtual function (VF). Two requesters share the bank: the physical-function (PF) host port and a VF port whose requester index says which function is accessing it. The PF can read and write any word by index. A VF has no address and always reaches its own word. Each word has two 16-bit halves. The low half carries host-to-function messages and belongs to the PF. The high half carries function-to-host messages and belongs to the VF.

The lowest bit of each half is a doorbell, and the bit above it marks the message origin. A doorbell counts as raised only when the doorbell bit and the origin bit are both 1. When the low half's doorbell is raised, the matching VF's interrupt line goes high. When the high half's doorbell is raised, the function's bit in the host pending vector goes high, and the host interrupt is the OR of that vector. The four bits above each origin bit hold the message type and the bits above those hold payload. The block stores these bits and does not interpret them. The receiver acknowledges a message by clearing the doorbell bit in the sender's half.

A sender that wants to claim the word first writes a fixed in-use marker into the other side's half. A VF may write that marker into the PF half, but it may change nothing else there apart from clearing the doorbell bit.

Top module: `pfvf_mbox_array`

## Requirements
- R1: After a synchronous active-low reset, every mailbox word reads 0, and `vf_irq`, `pf_pending` and `pf_irq` are all 0.
- R2: A PF write updates only the byte lanes selected by `pf_be` (bit n covers data bits 8n+7:8n) of the word chosen by `pf_addr`, and `pf_rdata` returns any in-range word the cycle after it is written.
- R3: `vf_irq[i]` is 1 exactly when bit 0 and bit 1 of word i are both 1. A word whose bit 0 is set with bit 1 at 0 raises no interrupt.
- R4: A VF write stores the enabled lanes 2 and 3 into bits 31:16 of its own word. `pf_pending[i]` is 1 exactly when bits 16 and 17 of word i are both 1, and `pf_irq` is the OR of `pf_pending`.
- R5: In the low half, a VF write with `vf_be[0]` set and `vf_wdata[0]` at 0 clears bit 0 and nothing else. Any other VF write to bits 15:0 is ignored, so a VF can never set bit 0.
- R6: A VF write with `vf_be[1:0]` = 2'b11 and `vf_wdata[15:0]` equal to the in-use marker (default 16'h5A5C) stores the marker into bits 15:0. A value that differs from the marker by one bit is not stored.
- R7: The PF acknowledges a message by writing bit 16 as 0. The function's `pf_pending` bit and `pf_irq` then drop in the cycle after the write.
- R8: A VF reads and writes only the word at index `vf_id`. The other words are unaffected by its writes.
- R9: A PF or VF index at or above the number of functions reads as 0, and a write through it changes no word.
- R10: When the PF and the VF write the same word in the same cycle, the PF's lanes 0 and 1 and the VF's lanes 2 and 3 take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_we | input | 1 | Host write strobe |
| pf_addr | input | ID_W | Host word index for read and write |
| pf_be | input | 4 | Host byte enables |
| pf_wdata | input | 32 | Host write data |
| pf_rdata | output | 32 | Host read data, combinational from the selected word |
| vf_we | input | 1 | Function write strobe |
| vf_id | input | ID_W | Index of the requesting function |
| vf_be | input | 4 | Function byte enables |
| vf_wdata | input | 32 | Function write data |
| vf_rdata | output | 32 | Function read data for its own word |
| vf_irq | output | NUM_VF | Per-function interrupt from the host doorbell |
| pf_irq | output | 1 | Host interrupt, OR of all pending bits |
| pf_pending | output | NUM_VF | Per-function raised-doorbell flags toward the host |

## Verification
The bench raises the host doorbell twice: once with the origin bit set and once with it clear, which separates a correct interrupt from one that ignores the origin. Function writes to the host half are tried three ways: as an acknowledge with bit 0 at 0, as an attempt to set bit 0, and as the exact marker against a marker with one bit off. These cases show whether the ownership filter is too loose or too strict. Writes from an in-range function are checked against the other words to confirm isolation. Out-of-range indices are used on both ports. A same-cycle write by both sides to one word, with all lanes enabled, shows which side wins each half.

// File: rtl/mbx_pkg.sv
// Package: shared widths and helpers for the mailbox bank.
// Assumes a 32-bit word split into two 16-bit halves of two byte lanes each.
package mbx_pkg;
    localparam int WORD_W  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = WORD_W / LANE_W;
    localparam int HALF_W  = WORD_W / 2;

    typedef logic [WORD_W-1:0] mbx_word_t;

    // A half carries a live doorbell when its doorbell and origin bits are both set.
    function automatic logic half_raised(input logic [HALF_W-1:0] half);
        return half[0] & half[1];
    endfunction
endpackage

// File: rtl/mbx_slot.sv
// Module: one mailbox word with side-aware write merging.
// The host owns lanes 0-1 and the function owns lanes 2-3. A non-owner may
// write the owner's half only when the owner is not writing that lane. For the
// function writing the host half, only a doorbell clear or the exact in-use
// marker takes effect. Assumes hit strobes are already qualified by index.
module mbx_slot
    import mbx_pkg::*;
#(
    parameter logic [HALF_W-1:0] IN_USE = 16'h5A5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_hit,
    input  logic [LANES-1:0]  pf_be,
    input  mbx_word_t         pf_wdata,
    input  logic              vf_hit,
    input  logic [LANES-1:0]  vf_be,
    input  mbx_word_t         vf_wdata,
    output mbx_word_t         q,
    output logic              ring_vf,
    output logic              ring_pf
);
    localparam int OWN_LO = LANES / 2;

    mbx_word_t nxt;
    logic      vf_marker;

    // Detect a function claiming the host half with the in-use marker.
    assign vf_marker = vf_hit && (vf_be[OWN_LO-1:0] == '1) &&
                       (vf_wdata[HALF_W-1:0] == IN_USE);

    // Merge both requesters' writes lane by lane, owner first.
    always_comb begin
        nxt = q;
        for (int b = 0; b < LANES; b++) begin
            if (b < OWN_LO) begin
                if (pf_hit && pf_be[b]) begin
                    nxt[b*LANE_W +: LANE_W] = pf_wdata[b*LANE_W +: LANE_W];
                end else if (vf_marker) begin
                    nxt[b*LANE_W +: LANE_W] = vf_wdata[b*LANE_W +: LANE_W];
                end else if (b == 0 && vf_hit && vf_be[0] && !vf_wdata[0]) begin
                    nxt[0] = 1'b0;
                end
            end else begin
                if (vf_hit && vf_be[b]) begin
                    nxt[b*LANE_W +: LANE_W] = vf_wdata[b*LANE_W +: LANE_W];
                end else if (pf_hit && pf_be[b]) begin
                    nxt[b*LANE_W +: LANE_W] = pf_wdata[b*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Hold the word; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // Doorbells seen by each side.
    assign ring_vf = half_raised(q[HALF_W-1:0]);
    assign ring_pf = half_raised(q[WORD_W-1:HALF_W]);
endmodule

// File: rtl/mbx_rd_port.sv
// Module: range-checked read selector over the flattened word bank.
// An index at or above NUM_VF returns zero. Purely combinational.
module mbx_rd_port
    import mbx_pkg::*;
#(
    parameter int NUM_VF = 6,
    parameter int ID_W   = 3
) (
    input  logic [ID_W-1:0]          sel,
    input  logic [NUM_VF*WORD_W-1:0] words,
    output mbx_word_t                rdata
);
    // Pick the addressed word, or zero when none matches.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_VF; k++) begin
            if (sel == ID_W'(k)) rdata = words[k*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/pfvf_mbox_array.sv
// Module: bank of per-function mailbox words shared by a host port and a
// function port. The host addresses any word. The function port reaches only
// the word at its requester index. Outputs one interrupt per function and a
// pending vector plus an OR-reduced interrupt toward the host. Assumes
// 2**ID_W >= NUM_VF; higher indices are treated as out of range.
module pfvf_mbox_array
    import mbx_pkg::*;
#(
    parameter int                NUM_VF = 6,
    parameter int                ID_W   = 3,
    parameter logic [HALF_W-1:0] IN_USE = 16'h5A5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_we,
    input  logic [ID_W-1:0]   pf_addr,
    input  logic [LANES-1:0]  pf_be,
    input  logic [WORD_W-1:0] pf_wdata,
    output logic [WORD_W-1:0] pf_rdata,
    input  logic              vf_we,
    input  logic [ID_W-1:0]   vf_id,
    input  logic [LANES-1:0]  vf_be,
    input  logic [WORD_W-1:0] vf_wdata,
    output logic [WORD_W-1:0] vf_rdata,
    output logic [NUM_VF-1:0] vf_irq,
    output logic              pf_irq,
    output logic [NUM_VF-1:0] pf_pending
);
    localparam int FLAT_W = NUM_VF * WORD_W;

    logic [FLAT_W-1:0] mbx_flat;

    // One storage slot per function; hits are decoded per index.
    for (genvar i = 0; i < NUM_VF; i++) begin : g_slot
        logic      pf_hit;
        logic      vf_hit;
        mbx_word_t q;

        assign pf_hit = pf_we && (pf_addr == ID_W'(i));
        assign vf_hit = vf_we && (vf_id == ID_W'(i));

        mbx_slot #(.IN_USE(IN_USE)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .pf_hit   (pf_hit),
            .pf_be    (pf_be),
            .pf_wdata (pf_wdata),
            .vf_hit   (vf_hit),
            .vf_be    (vf_be),
            .vf_wdata (vf_wdata),
            .q        (q),
            .ring_vf  (vf_irq[i]),
            .ring_pf  (pf_pending[i])
        );

        assign mbx_flat[i*WORD_W +: WORD_W] = q;
    end

    // Host view: any word by address.
    mbx_rd_port #(.NUM_VF(NUM_VF), .ID_W(ID_W)) u_pf_rd (
        .sel   (pf_addr),
        .words (mbx_flat),
        .rdata (pf_rdata)
    );

    // Function view: only the requester's own word.
    mbx_rd_port #(.NUM_VF(NUM_VF), .ID_W(ID_W)) u_vf_rd (
        .sel   (vf_id),
        .words (mbx_flat),
        .rdata (vf_rdata)
    );

    // Host interrupt collects every raised function doorbell.
    assign pf_irq = |pf_pending;
endmodule

// File: rtl/pfvf_mbox_array_chk.sv
// Module: temporal checks for the mailbox bank, bound into the top module.
// Assumes the flattened word bank is visible in the top scope as mbx_flat.
module pfvf_mbox_array_chk
    import mbx_pkg::*;
#(
    parameter int                NUM_VF = 6,
    parameter int                ID_W   = 3,
    parameter logic [HALF_W-1:0] IN_USE = 16'h5A5C
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pf_we,
    input  logic [ID_W-1:0]          pf_addr,
    input  logic [LANES-1:0]         pf_be,
    input  logic [WORD_W-1:0]        pf_wdata,
    input  logic                     vf_we,
    input  logic [ID_W-1:0]          vf_id,
    input  logic [LANES-1:0]         vf_be,
    input  logic [WORD_W-1:0]        vf_wdata,
    input  logic [WORD_W-1:0]        vf_rdata,
    input  logic [NUM_VF-1:0]        vf_irq,
    input  logic [NUM_VF*WORD_W-1:0] mbx_flat
);
    // R9: a function index out of range changes nothing.
    p_oor_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_we && int'(vf_id) >= NUM_VF && !pf_we) |=> $stable(mbx_flat));

    // R9: an out-of-range function read returns zero.
    p_oor_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(vf_id) >= NUM_VF) |-> (vf_rdata == '0));

    for (genvar i = 0; i < NUM_VF; i++) begin : g_chk
        // R5: a function doorbell can only rise after a host write to that word.
        p_vfirq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(vf_irq[i]) |-> $past(pf_we && pf_addr == ID_W'(i)));

        // R5: bits 15:1 are untouched by a non-marker function write alone.
        p_vf_low_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (vf_we && vf_id == ID_W'(i) && !(pf_we && pf_addr == ID_W'(i)) &&
             !(vf_be[1:0] == 2'b11 && vf_wdata[HALF_W-1:0] == IN_USE))
            |=> (mbx_flat[i*WORD_W+1 +: HALF_W-1] ==
                 $past(mbx_flat[i*WORD_W+1 +: HALF_W-1])));

        // R5: a function acknowledge drops its interrupt.
        p_vf_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (vf_we && vf_id == ID_W'(i) && vf_be[0] && !vf_wdata[0] &&
             !(pf_we && pf_addr == ID_W'(i) && pf_be[0])) |=> !vf_irq[i]);

        // R2: a full host write with no function write lands as written.
        p_pf_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (pf_we && pf_addr == ID_W'(i) && pf_be == 4'hF && !vf_we)
            |=> (mbx_flat[i*WORD_W +: WORD_W] == $past(pf_wdata)));

        // R10: on a full collision each side keeps its own half.
        p_owner_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (pf_we && vf_we && pf_addr == ID_W'(i) && vf_id == ID_W'(i) &&
             pf_be == 4'hF && vf_be == 4'hF)
            |=> (mbx_flat[i*WORD_W +: WORD_W] ==
                 $past({vf_wdata[WORD_W-1:HALF_W], pf_wdata[HALF_W-1:0]})));
    end
endmodule

bind pfvf_mbox_array pfvf_mbox_array_chk #(
    .NUM_VF (NUM_VF),
    .ID_W   (ID_W),
    .IN_USE (IN_USE)
) u_chk (.*);

// File: tb/pfvf_mbox_array_bench.sv
`timescale 1ns/1ps
module pfvf_mbox_array_bench;
    localparam int NUM_VF = 6;
    localparam int ID_W   = 3;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pf_we = 1'b0;
    logic [ID_W-1:0]   pf_addr = '0;
    logic [3:0]        pf_be = '0;
    logic [31:0]       pf_wdata = '0;
    logic [31:0]       pf_rdata;
    logic              vf_we = 1'b0;
    logic [ID_W-1:0]   vf_id = '0;
    logic [3:0]        vf_be = '0;
    logic [31:0]       vf_wdata = '0;
    logic [31:0]       vf_rdata;
    logic [NUM_VF-1:0] vf_irq;
    logic              pf_irq;
    logic [NUM_VF-1:0] pf_pending;

    exp_t sb[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #2.5 clk = ~clk;

    pfvf_mbox_array #(.NUM_VF(NUM_VF), .ID_W(ID_W)) u_pfvf_mbox_array (
        .clk(clk), .rst_n(rst_n),
        .pf_we(pf_we), .pf_addr(pf_addr), .pf_be(pf_be), .pf_wdata(pf_wdata),
        .pf_rdata(pf_rdata),
        .vf_we(vf_we), .vf_id(vf_id), .vf_be(vf_be), .vf_wdata(vf_wdata),
        .vf_rdata(vf_rdata),
        .vf_irq(vf_irq), .pf_irq(pf_irq), .pf_pending(pf_pending)
    );

    // Monitor: after each edge, pop and compare queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t  it;
                logic [31:0] obs;
                it = sb.pop_front();
                case (it.kind)
                    0:       obs = pf_rdata;
                    1:       obs = vf_rdata;
                    2:       obs = 32'(vf_irq);
                    3:       obs = 32'(pf_pending);
                    default: obs = 32'(pf_irq);
                endcase
                n_tests++;
                if (obs !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
                end
            end
        end
    end

    task automatic pf_write(input int a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        pf_we = 1'b1; pf_addr = ID_W'(a); pf_be = be; pf_wdata = d;
        @(negedge clk);
        pf_we = 1'b0;
    endtask

    task automatic vf_write(input int id, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        vf_we = 1'b1; vf_id = ID_W'(id); vf_be = be; vf_wdata = d;
        @(negedge clk);
        vf_we = 1'b0;
    endtask

    task automatic both_write(input int a, input logic [31:0] pd, input logic [31:0] vd);
        @(negedge clk);
        pf_we = 1'b1; pf_addr = ID_W'(a); pf_be = 4'hF; pf_wdata = pd;
        vf_we = 1'b1; vf_id = ID_W'(a);   vf_be = 4'hF; vf_wdata = vd;
        @(negedge clk);
        pf_we = 1'b0; vf_we = 1'b0;
    endtask

    // Driver side of the scoreboard: set the read index, queue the expectation.
    task automatic expect_pf(input string tag, input int a, input logic [31:0] e);
        @(negedge clk);
        pf_addr = ID_W'(a);
        sb.push_back('{tag, 0, e});
    endtask

    task automatic expect_vf(input string tag, input int id, input logic [31:0] e);
        @(negedge clk);
        vf_id = ID_W'(id);
        sb.push_back('{tag, 1, e});
    endtask

    task automatic expect_out(input string tag, input int kind, input logic [31:0] e);
        @(negedge clk);
        sb.push_back('{tag, kind, e});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_pf ("R1 word0 after reset", 0, 32'h0);
        expect_out("R1 vf_irq after reset", 2, 32'h0);
        expect_out("R1 pending after reset", 3, 32'h0);
        expect_out("R1 pf_irq after reset", 4, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2/R3: host doorbell with origin set raises the function interrupt.
        pf_write(2, 4'b0011, 32'h0000_0023);
        expect_pf ("R2 word2 low half", 2, 32'h0000_0023);
        expect_out("R3 vf_irq origin set", 2, 32'h04);
        // R3: origin clear gives no interrupt.
        pf_write(3, 4'b0011, 32'h0000_0001);
        expect_pf ("R3 word3 stored", 3, 32'h0000_0001);
        expect_out("R3 vf_irq origin clear", 2, 32'h04);

        // R2: single lane host write into the upper half.
        pf_write(1, 4'b0100, 32'hFFFF_FFFF);
        expect_pf ("R2 lane2 only", 1, 32'h00FF_0000);
        expect_out("R4 pending word1", 3, 32'h02);
        expect_out("R4 pf_irq set", 4, 32'h1);
        pf_write(1, 4'b0100, 32'h0);
        expect_out("R7 pending cleared", 3, 32'h0);

        // R8/R4: function reads and writes its own word.
        expect_vf ("R8 vf2 own read", 2, 32'h0000_0023);
        vf_write(2, 4'b1100, 32'h1237_0000);
        expect_pf ("R4 vf upper stored", 2, 32'h1237_0023);
        expect_out("R4 pending vf2", 3, 32'h04);
        expect_out("R4 pf_irq vf2", 4, 32'h1);

        // R5: acknowledge clears bit 0 only; set attempts ignored.
        vf_write(2, 4'b0001, 32'h0000_00FE);
        expect_pf ("R5 ack clears bit0", 2, 32'h1237_0022);
        expect_out("R5 vf_irq dropped", 2, 32'h0);
        vf_write(2, 4'b0001, 32'h0000_00FF);
        vf_write(2, 4'b0010, 32'h0000_FF00);
        expect_pf ("R5 vf cannot set low", 2, 32'h1237_0022);
        expect_out("R5 vf_irq stays low", 2, 32'h0);

        // R7: host acknowledge.
        pf_write(2, 4'b0100, 32'h0036_0000);
        expect_pf ("R7 host ack word", 2, 32'h1236_0022);
        expect_out("R7 pending low", 3, 32'h0);
        expect_out("R7 pf_irq low", 4, 32'h0);

        // R6: exact marker stored, near-miss not.
        vf_write(4, 4'b0011, 32'h0000_5A5C);
        expect_pf ("R6 marker stored", 4, 32'h0000_5A5C);
        vf_write(4, 4'b0011, 32'h0000_0000 | 32'h5A5C ^ 32'h0100);
        expect_pf ("R6 near marker ignored", 4, 32'h0000_5A5C);

        // R8: a write from function 3 leaves other words alone.
        expect_vf ("R8 vf3 own read", 3, 32'h0000_0001);
        vf_write(3, 4'b1111, 32'hFFFF_FFFE);
        expect_vf ("R8 vf3 after write", 3, 32'hFFFF_0000);
        expect_pf ("R8 word2 untouched", 2, 32'h1236_0022);
        expect_out("R8 pending vf3", 3, 32'h08);

        // R9: out-of-range indices.
        vf_write(7, 4'b1111, 32'h0003_0000);
        expect_out("R9 oor vf write no effect", 3, 32'h08);
        expect_vf ("R9 oor vf read", 7, 32'h0);
        pf_write(6, 4'b1111, 32'hFFFF_FFFF);
        expect_pf ("R9 oor pf read6", 6, 32'h0);
        expect_pf ("R9 oor pf read7", 7, 32'h0);
        expect_out("R9 vf_irq unchanged", 2, 32'h0);
        expect_out("R9 pending unchanged", 3, 32'h08);

        // R10: same-cycle collision on word 5.
        both_write(5, 32'hAAAA_1103, 32'h5557_FFFE);
        expect_pf ("R10 collision merge", 5, 32'h5557_1103);
        expect_out("R10 pending", 3, 32'h28);
        expect_out("R10 vf_irq", 2, 32'h20);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule